// File: doc/BRIEF.md
# Fibonacci LED Sequence Stepper

This block drives a bank of LEDs with the terms of the Fibonacci sequence in plain binary. Each press of an advance key moves the display on by one term. A press of a clear key puts the sequence back at its start at any moment. Both keys arrive as debounced, active-low levels. The block finds the press edges itself, so a key that is held down counts as a single press.

The sum for the next term is formed one bit wider than the display. When that sum does not fit, the block does not show a truncated value. It plays a blink animation instead: all LEDs are switched on and off a set number of times, and each on or off phase lasts a set number of clock cycles. When the animation ends, the sequence starts again by itself. Advance presses have no effect while the animation runs. A clear press stops the animation at once.

Top module: `fib_led_stepper`

## Requirements
- R1: After reset the internal term pair is (0, 1) and `led_o` shows 1.
- R2: Each accepted advance press replaces the pair (a, b) with (b, a+b), and `led_o` shows the new b in unsigned binary on the cycle after the press edge.
- R3: A press is the high-to-low transition of a key level. Holding a key low for many cycles gives one step, and releasing it gives none.
- R4: A clear press (a high-to-low edge on `clr_key_ni`) resets the pair to (0, 1), so `led_o` reads 1 on the next cycle. This holds in every state.
- R5: If a + b does not fit in `LED_W` bits, an advance press starts the blink animation, and no truncated sum ever appears on `led_o`. Outside the animation, `led_o` is never zero.
- R6: The animation has 2*`BLINKS` phases of `PHASE_CYC` cycles each. The first phase is all ones, and the phases alternate between all ones and all zeros.
- R7: When the last phase ends, the pair is (0, 1) and `led_o` reads 1 on the next cycle.
- R8: Advance presses during the animation are ignored: the animation keeps its length, and the sequence after it starts at 1.
- R9: A clear press during the animation ends it at the next clock edge, `led_o` reads 1, and the animation does not come back.
- R10: When both keys fall in the same cycle, the clear press wins and the advance press is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adv_key_ni | input | 1 | Debounced advance key level, low when pressed |
| clr_key_ni | input | 1 | Debounced clear key level, low when pressed |
| led_o | output | LED_W | LED vector: the current term or the blink pattern |

## Verification
The stepping function is driven in three ways. A run of single taps walks the full sequence up to the largest term that fits, which separates a correct a+b update from an off-by-one start. A key held low for several cycles shows whether the design steps on the edge or on the level. A tap given exactly when the next sum no longer fits is checked phase by phase through the animation, with an extra advance tap inside it, which separates a wrapping or saturating design from one that blinks for the correct length and then restarts. Clear presses given mid-sequence, mid-animation, and in the same cycle as an advance press show that the return to the start has priority and does not leave an animation pending.

// File: rtl/fib_pkg.sv
package fib_pkg;
  typedef enum logic {
    ST_SHOW  = 1'b0,
    ST_BLINK = 1'b1
  } fib_state_e;
endpackage

// File: rtl/fib_key_edge.sv
module fib_key_edge #(
  parameter int unsigned N_KEYS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_KEYS-1:0] key_ni,
  output logic [N_KEYS-1:0] press_o
);
  logic [N_KEYS-1:0] key_q;

  for (genvar k = 0; k < N_KEYS; k++) begin : g_key
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) key_q[k] <= 1'b1;
      else         key_q[k] <= key_ni[k];
    end
    // released last cycle, pressed now
    assign press_o[k] = key_q[k] & ~key_ni[k];
  end
endmodule

// File: rtl/fib_term_gen.sv
module fib_term_gen #(
  parameter int unsigned LED_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [LED_W-1:0] term_o,
  output logic             ovf_o
);
  localparam int unsigned SUM_W = LED_W + 1;

  logic [LED_W-1:0] prev_q, cur_q;
  logic [SUM_W-1:0] sum;

  assign sum = {1'b0, prev_q} + {1'b0, cur_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      cur_q  <= LED_W'(1);
    end else if (clear_i) begin
      prev_q <= '0;
      cur_q  <= LED_W'(1);
    end else if (step_i) begin
      prev_q <= cur_q;
      cur_q  <= sum[LED_W-1:0];
    end
  end

  assign term_o = cur_q;
  assign ovf_o  = sum[SUM_W-1];
endmodule

// File: rtl/fib_blink_seq.sv
module fib_blink_seq #(
  parameter int unsigned PHASE_CYC = 12_500_000,
  parameter int unsigned BLINKS    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic lit_o,
  output logic done_o
);
  localparam int unsigned N_PHASE = 2 * BLINKS;
  localparam int unsigned CNT_W   = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam int unsigned PH_W    = $clog2(N_PHASE + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PHASE_CYC - 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(N_PHASE - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [PH_W-1:0]  phase_q;
  logic             phase_end;

  assign phase_end = run_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= '0;
    end else if (!run_i || done_o) begin
      cnt_q   <= '0;
      phase_q <= '0;
    end else if (phase_end) begin
      cnt_q   <= '0;
      phase_q <= phase_q + PH_W'(1);
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // even phases lit, odd phases dark
  assign lit_o  = run_i && !phase_q[0];
  assign done_o = phase_end && (phase_q == PH_LAST);
endmodule

// File: rtl/fib_led_stepper.sv
module fib_led_stepper
  import fib_pkg::*;
#(
  parameter int unsigned LED_W     = 8,
  parameter int unsigned PHASE_CYC = 12_500_000,
  parameter int unsigned BLINKS    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_key_ni,
  input  logic             clr_key_ni,
  output logic [LED_W-1:0] led_o
);
  fib_state_e       state_q, state_d;
  logic [1:0]       press;
  logic             adv_press, clr_press;
  logic             term_ovf, term_step, term_clear;
  logic [LED_W-1:0] term;
  logic             blink_on, blink_lit, blink_done;

  fib_key_edge #(.N_KEYS(2)) i_key_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .key_ni ({clr_key_ni, adv_key_ni}),
    .press_o(press)
  );
  assign adv_press = press[0];
  assign clr_press = press[1];

  assign blink_on   = (state_q == ST_BLINK);
  assign term_step  = !blink_on && adv_press && !clr_press && !term_ovf;
  assign term_clear = clr_press || blink_done;

  fib_term_gen #(.LED_W(LED_W)) i_term_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(term_clear),
    .step_i (term_step),
    .term_o (term),
    .ovf_o  (term_ovf)
  );

  fib_blink_seq #(.PHASE_CYC(PHASE_CYC), .BLINKS(BLINKS)) i_blink_seq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (blink_on),
    .lit_o (blink_lit),
    .done_o(blink_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_SHOW:  if (!clr_press && adv_press && term_ovf) state_d = ST_BLINK;
      ST_BLINK: if (clr_press || blink_done)             state_d = ST_SHOW;
      default:                                           state_d = ST_SHOW;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_SHOW;
    else         state_q <= state_d;
  end

  assign led_o = blink_on ? {LED_W{blink_lit}} : term;
endmodule

// File: rtl/fib_led_stepper_chk.sv
module fib_led_stepper_chk #(
  parameter int unsigned LED_W     = 8,
  parameter int unsigned PHASE_CYC = 12_500_000,
  parameter int unsigned BLINKS    = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             adv_key_ni,
  input logic             clr_key_ni,
  input logic [LED_W-1:0] led_o,
  input logic             in_blink_i
);
  localparam int unsigned SPAN = 2 * BLINKS * PHASE_CYC;
  localparam int unsigned BW   = $clog2(SPAN + 1);

  logic [BW-1:0] blink_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         blink_cnt_q <= '0;
    else if (in_blink_i) blink_cnt_q <= blink_cnt_q + BW'(1);
    else                 blink_cnt_q <= '0;
  end

  // R3
  held_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_blink_i && !adv_key_ni && !$past(adv_key_ni) && !$fell(clr_key_ni))
    |=> (led_o == $past(led_o)));

  // R4
  clear_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clr_key_ni) |=> (led_o == LED_W'(1)));

  // R5
  no_zero_term_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_blink_i |-> (led_o != '0));

  // R6
  blink_pattern_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_blink_i |-> ((led_o == '0) || (led_o == '1)));

  // R6
  blink_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_blink_i |-> (blink_cnt_q < BW'(SPAN)));

  // R7
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_blink_i) |-> (led_o == LED_W'(1)));
endmodule

bind fib_led_stepper fib_led_stepper_chk #(
  .LED_W(LED_W), .PHASE_CYC(PHASE_CYC), .BLINKS(BLINKS)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .adv_key_ni(adv_key_ni),
  .clr_key_ni(clr_key_ni),
  .led_o     (led_o),
  .in_blink_i(blink_on)
);

// File: tb/test_fib_led_stepper.sv
module test_fib_led_stepper;
  localparam int unsigned LED_W = 8;
  localparam int unsigned PH    = 4;
  localparam int unsigned BL    = 3;
  localparam int unsigned SPAN  = 2 * BL * PH;
  localparam int unsigned NVEC  = 18;

  // {clear_op, expected led}
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b0, 8'd1},  {1'b0, 8'd2},  {1'b0, 8'd3},   {1'b0, 8'd5},
    {1'b0, 8'd8},  {1'b1, 8'd1},  {1'b0, 8'd1},   {1'b0, 8'd2},
    {1'b0, 8'd3},  {1'b0, 8'd5},  {1'b0, 8'd8},   {1'b0, 8'd13},
    {1'b0, 8'd21}, {1'b0, 8'd34}, {1'b0, 8'd55},  {1'b0, 8'd89},
    {1'b0, 8'd144},{1'b0, 8'd233}
  };

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             adv_key_ni = 1'b1;
  logic             clr_key_ni = 1'b1;
  logic [LED_W-1:0] led_o;
  int               n_chk = 0;
  int               n_err = 0;
  bit               done = 1'b0;

  always #10 clk = ~clk;

  fib_led_stepper #(.LED_W(LED_W), .PHASE_CYC(PH), .BLINKS(BL)) i_fib_led_stepper (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .adv_key_ni(adv_key_ni),
    .clr_key_ni(clr_key_ni),
    .led_o     (led_o)
  );

  task automatic check(input string req, input logic [LED_W-1:0] exp);
    n_chk++;
    if (led_o !== exp) begin
      n_err++;
      $display("FAIL %s: led_o=%0d expected %0d", req, led_o, exp);
    end
  endtask

  // tap a key for one cycle; returns at the negedge after the registering edge
  task automatic tap(input bit clr, input bit adv);
    @(negedge clk);
    if (clr) clr_key_ni = 1'b0;
    if (adv) adv_key_ni = 1'b0;
    @(negedge clk);
    clr_key_ni = 1'b1;
    adv_key_ni = 1'b1;
  endtask

  task automatic climb_to_top();
    for (int i = 0; i < 12; i++) tap(1'b0, 1'b1);
    check("R2 top term", 8'd233);
  endtask

  initial begin
    fork
      begin
        repeat (5) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        check("R1 reset value", 8'd1);

        // R2 R4: vector table walk
        for (int v = 0; v < NVEC; v++) begin
          tap(VEC[v][8], !VEC[v][8]);
          check(VEC[v][8] ? "R4 clear mid-sequence" : "R2 next term", VEC[v][7:0]);
        end

        // R5 R6 R8: overflow tap, animation with a stray advance tap
        @(negedge clk);
        adv_key_ni = 1'b0;
        @(negedge clk);
        adv_key_ni = 1'b1;
        for (int k = 0; k <= SPAN; k++) begin
          if (k == 2) adv_key_ni = 1'b0;
          if (k == 3) adv_key_ni = 1'b1;
          if (k < SPAN) check("R6 R8 blink phase", ((k / PH) % 2 == 0) ? 8'hFF : 8'h00);
          else          check("R7 R8 restart after blink", 8'd1);
          @(negedge clk);
        end
        tap(1'b0, 1'b1);
        check("R7 first term after restart", 8'd1);
        tap(1'b0, 1'b1);
        check("R7 second term after restart", 8'd2);

        // R3: hold advance several cycles, then release
        @(negedge clk);
        adv_key_ni = 1'b0;
        repeat (6) @(negedge clk);
        check("R3 held key steps once", 8'd3);
        adv_key_ni = 1'b1;
        repeat (3) @(negedge clk);
        check("R3 release has no effect", 8'd3);

        // R9: clear during animation
        tap(1'b1, 1'b0);
        climb_to_top();
        @(negedge clk);
        adv_key_ni = 1'b0;
        @(negedge clk);
        adv_key_ni = 1'b1;
        check("R5 overflow starts blink", 8'hFF);
        repeat (5) @(negedge clk);
        check("R6 dark phase", 8'h00);
        clr_key_ni = 1'b0;
        @(negedge clk);
        clr_key_ni = 1'b1;
        check("R9 abort shows start", 8'd1);
        for (int j = 0; j < 4; j++) begin
          repeat (8) @(negedge clk);
          check("R9 no resumed blink", 8'd1);
        end
        tap(1'b0, 1'b1);
        check("R9 sequence after abort", 8'd1);
        tap(1'b0, 1'b1);
        check("R9 sequence after abort", 8'd2);

        // R10: both keys fall together
        tap(1'b0, 1'b1);
        check("R2 before simultaneous", 8'd3);
        tap(1'b1, 1'b1);
        check("R10 clear wins", 8'd1);
        tap(1'b0, 1'b1);
        check("R10 pair reset to 0,1", 8'd1);
        tap(1'b0, 1'b1);
        check("R10 pair reset to 0,1", 8'd2);

        // R1: asynchronous reset mid-sequence
        @(negedge clk);
        rst_ni = 1'b0;
        @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        check("R1 reset mid-sequence", 8'd1);
        done = 1'b1;
      end
      begin
        repeat (5000) @(negedge clk);
        if (!done) begin
          n_chk++;
          n_err++;
          $display("FAIL watchdog: run did not finish");
        end
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule